// File: doc/BRIEF.md
# SDRAM Auto-Refresh Request Scheduler

This block decides when an external SDRAM must be refreshed and asks the SDRAM command sequencer to do it. It stays silent after reset. A one-cycle start strobe begins its work. The strobe first runs one refresh round straight away on every memory area enabled in the area mask. When that round has completed, the block loads a 6-bit interval into a down-counter, and the start bit then clears itself.

From then on a 5-bit divider slows the counter to one step per 32 bus clocks. Each time the count runs out, the counter reloads and a new refresh round begins. A mode bit selects the round shape:

- **Distributed mode:** every round is one refresh command.
- **Burst mode:** every round is a programmed number of commands (1 to 15) issued back to back, and the interval is stretched by that same number.

Each command is a request held high until the sequencer acknowledges it. The request carries the mask of areas to refresh. Writing an interval of zero halts further automatic rounds.

Top module: `refresh_sched`

## Requirements
- R1: After reset req_o, start_o and req_areas_o are 0, and no request is raised until start_wr_i is pulsed.
- R2: A start_wr_i pulse sets start_o and raises req_o at the next clock edge, with req_areas_o equal to area_en_i sampled at the pulse. The request and its area mask stay stable until acknowledged.
- R3: A round is one command in distributed mode (burst_i=0). In burst mode (burst_i=1) it is count_i commands, with a count_i of 0 taken as 1. Each cycle with ack_i=1 and req_o=1 completes one command.
- R4: start_o stays 1 until the startup round has completed and the interval has been loaded, then reads 0. With an all-zero area mask no command is issued, start_o is 1 for exactly one cycle after the pulse, and it is 0 after the second edge.
- R5: After the reload, rounds begin every interval_i×32 clocks in distributed mode, and every interval_i×32×count_i clocks in burst mode (count 0 counted as 1).
- R6: With interval_i set to 0 while the timer runs, no further round starts.
- R7: The timer keeps running while commands wait for acknowledge, so a slow acknowledge does not change the round spacing.
- R8: A round that falls due while the previous round is unfinished is queued and starts as soon as that round completes. At most one round is held in the queue, and further due rounds are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr_i | input | 1 | One-cycle write of 1 to the start bit |
| interval_i | input | 6 | Refresh interval in units of 32 clocks; 0 stops refresh |
| burst_i | input | 1 | 1 = burst rounds, 0 = distributed rounds |
| count_i | input | 4 | Commands per burst round (0 means 1) |
| area_en_i | input | AREAS | Mask of enabled SDRAM areas |
| ack_i | input | 1 | Sequencer accepts the current command |
| start_o | output | 1 | Start bit readback; self-clearing |
| req_o | output | 1 | Refresh command request |
| req_areas_o | output | AREAS | Areas the current command refreshes |

## Verification
The counter running out and the last acknowledge of a round can land in the same cycle. So can a second due round and an unfinished one. The bench withholds acknowledge across several intervals and then releases it in two single-cycle pulses. It judges by whether the request stays high after the first pulse and drops after the second. A slow acknowledge that stretches every round over a timer step shows that the spacing stays fixed while commands are in flight.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    localparam int DIV_W = 5;
    localparam int CNT_W = 4;
    localparam int INT_W = 6;

    function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
        return (c == '0) ? CNT_W'(1) : c;
    endfunction
endpackage

// File: rtl/refresh_prescaler.sv
module refresh_prescaler
    import refresh_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             burst,
    input  logic [CNT_W-1:0] count,
    output logic             tick
);
    localparam logic [DW-1:0] DIV_MAX = '1;

    typedef struct packed {
        logic [DW-1:0]    div;
        logic [CNT_W-1:0] scl;
    } st_t;

    st_t s_d, s_q;
    logic [CNT_W-1:0] scl_inc;

    always_comb begin
        s_d     = s_q;
        tick    = 1'b0;
        scl_inc = s_q.scl + 1'b1;
        if (!run) begin
            s_d = '0;
        end else begin
            s_d.div = s_q.div + 1'b1;
            if (s_q.div == DIV_MAX) begin
                if (!burst || scl_inc >= eff_count(count)) begin
                    tick    = 1'b1;
                    s_d.scl = '0;
                end else begin
                    s_d.scl = scl_inc;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/refresh_round.sv
module refresh_round
    import refresh_pkg::*;
#(
    parameter int AREAS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             drop,
    input  logic             burst,
    input  logic [CNT_W-1:0] count,
    input  logic [AREAS-1:0] areas_i,
    input  logic             ack,
    output logic             req,
    output logic [AREAS-1:0] areas_o,
    output logic             idle
);
    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic             pend;
        logic [AREAS-1:0] areas;
    } st_t;

    st_t s_d, s_q;
    logic [CNT_W-1:0] rem_n;
    logic [CNT_W-1:0] len;
    logic             go;

    always_comb begin
        s_d   = s_q;
        go    = 1'b0;
        len   = burst ? eff_count(count) : CNT_W'(1);
        rem_n = (ack && s_q.rem != '0) ? s_q.rem - 1'b1 : s_q.rem;
        s_d.rem = rem_n;
        if (launch) begin
            if (rem_n == '0 && !s_q.pend) go = 1'b1;
            else                          s_d.pend = 1'b1;
        end
        if (s_q.pend && rem_n == '0) begin
            go       = 1'b1;
            s_d.pend = launch;
        end
        if (drop) s_d.pend = 1'b0;
        if (go) begin
            s_d.rem   = (areas_i == '0) ? '0 : len;
            s_d.areas = areas_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req     = (s_q.rem != '0);
    assign areas_o = s_q.areas;
    assign idle    = (s_q.rem == '0) && !s_q.pend;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int AREAS = 4,
    parameter int IW    = INT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr_i,
    input  logic [IW-1:0]    interval_i,
    input  logic             burst_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [AREAS-1:0] area_en_i,
    input  logic             ack_i,
    output logic             start_o,
    output logic             req_o,
    output logic [AREAS-1:0] req_areas_o
);
    typedef struct packed {
        logic [IW-1:0] cnt;
        logic          active;
        logic          start;
    } st_t;

    st_t  s_d, s_q;
    logic tick, rnd_idle, start_fire, stop, under;

    refresh_prescaler #(.DW(DIV_W)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.active),
        .burst (burst_i),
        .count (count_i),
        .tick  (tick)
    );

    refresh_round #(.AREAS(AREAS)) i_round (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (start_fire || under),
        .drop    (stop),
        .burst   (burst_i),
        .count   (count_i),
        .areas_i (area_en_i),
        .ack     (ack_i),
        .req     (req_o),
        .areas_o (req_areas_o),
        .idle    (rnd_idle)
    );

    always_comb begin
        s_d        = s_q;
        start_fire = start_wr_i && !s_q.start;
        stop       = s_q.active && (interval_i == '0);
        under      = s_q.active && !stop && tick && (s_q.cnt <= IW'(1));
        if (start_fire) begin
            s_d.start  = 1'b1;
            s_d.active = 1'b0;
        end else if (s_q.start && rnd_idle) begin
            s_d.start  = 1'b0;
            s_d.cnt    = interval_i;
            s_d.active = (interval_i != '0);
        end else if (stop) begin
            s_d.active = 1'b0;
        end else if (s_q.active && tick) begin
            s_d.cnt = under ? interval_i : s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_o = s_q.start;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int AREAS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_wr_i,
    input logic             ack_i,
    input logic             start_o,
    input logic             req_o,
    input logic [AREAS-1:0] req_areas_o
);
    logic seen_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen_start <= 1'b0;
        else if (start_wr_i) seen_start <= 1'b1;
    end

    p_quiet_until_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start |-> !req_o);

    p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr_i && !start_o) |=> (start_o && req_o) || (start_o && req_areas_o == '0));

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(req_areas_o)));

    p_clear_when_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_o) |-> !req_o);
endmodule

bind refresh_sched refresh_sched_chk #(.AREAS(AREAS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_wr_i  (start_wr_i),
    .ack_i       (ack_i),
    .start_o     (start_o),
    .req_o       (req_o),
    .req_areas_o (req_areas_o)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
    localparam int AREAS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_wr = 1'b0;
    logic [5:0] interval = '0;
    logic burst = 1'b0;
    logic [3:0] count = '0;
    logic [AREAS-1:0] mask = '0;
    logic ack = 1'b0;
    logic start_o, req_o;
    logic [AREAS-1:0] areas_o;

    int checks = 0, errors = 0;
    int cyc = 0, rises = 0, last_rise = 0, accepted = 0;
    int mode = 0, dly = 0;
    logic req_prev = 1'b0;
    bit done = 0;

    refresh_sched #(.AREAS(AREAS)) i_refresh_sched (
        .clk(clk), .rst_n(rst_n), .start_wr_i(start_wr), .interval_i(interval),
        .burst_i(burst), .count_i(count), .area_en_i(mask), .ack_i(ack),
        .start_o(start_o), .req_o(req_o), .req_areas_o(areas_o)
    );

    always #10 clk = ~clk;

    function automatic int exp_len(input logic b, input logic [3:0] c);
        return b ? ((c == 0) ? 1 : int'(c)) : 1;
    endfunction

    function automatic int exp_period(input int n, input logic b, input logic [3:0] c);
        return n * 32 * exp_len(b, c);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // responder and monitor: 0 immediate ack, 1 hold, 2 slow ack, 3 manual
    initial forever begin
        @(negedge clk);
        cyc++;
        if (req_o && !req_prev) begin rises++; last_rise = cyc; end
        req_prev = req_o;
        case (mode)
            0: begin ack = req_o; if (req_o) accepted++; end
            1: ack = 1'b0;
            2: begin
                if (req_o && !ack) dly++;
                if (dly >= 20) begin ack = 1'b1; dly = 0; accepted++; end
                else ack = 1'b0;
            end
            default: ;
        endcase
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start;
        @(negedge clk); start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
    endtask

    task automatic wait_rise(output int t);
        int r0 = rises;
        while (rises == r0) @(negedge clk);
        t = last_rise;
    endtask

    task automatic drain;
        interval = '0;
        mode = 0;
        cycles(40);
    endtask

    initial begin
        int t1, t2, a0, r0;
        cycles(3);
        check("R1 req after reset", req_o, 0);
        check("R1 start after reset", start_o, 0);
        check("R1 areas after reset", areas_o, 0);
        rst_n = 1'b1;
        interval = 6'd2; mask = 4'b0101;
        cycles(200);
        check("R1 no request before start", rises, 0);

        // directed distributed start
        a0 = accepted;
        pulse_start;
        check("R2 start_o set", start_o, 1);
        check("R2 req raised", req_o, 1);
        check("R2 areas", areas_o, 4'b0101);
        while (start_o) @(negedge clk);
        check("R3 distributed round length", accepted - a0, 1);
        check("R4 start reads 0 after reload", start_o, 0);
        wait_rise(t1); wait_rise(t2);
        check("R5 distributed period", t2 - t1, exp_period(2, 0, 0));

        // burst with count 0 -> one command, period unscaled
        drain;
        burst = 1'b1; count = 4'd0; interval = 6'd1; mask = 4'b1000;
        a0 = accepted;
        pulse_start;
        while (start_o) @(negedge clk);
        check("R3 burst count zero as one", accepted - a0, 1);
        wait_rise(t1); wait_rise(t2);
        check("R5 burst count zero period", t2 - t1, exp_period(1, 1, 0));

        // random trials
        process::self().srandom(1234);
        for (int k = 0; k < 6; k++) begin
            int n;
            logic b;
            logic [3:0] c;
            logic [AREAS-1:0] m;
            drain;
            n = $urandom_range(1, 3);
            b = 1'($urandom_range(0, 1));
            c = 4'($urandom_range(0, 6));
            m = AREAS'($urandom_range(1, (1 << AREAS) - 1));
            burst = b; count = c; interval = 6'(n); mask = m;
            a0 = accepted;
            pulse_start;
            check("R2 random areas", areas_o, m);
            while (start_o) @(negedge clk);
            check("R3 random round length", accepted - a0, exp_len(b, c));
            wait_rise(t1);
            a0 = accepted;
            wait_rise(t2);
            check("R5 random period", t2 - t1, exp_period(n, b, c));
            check("R3 random periodic round length", accepted - a0, exp_len(b, c));
        end

        // R6 stop by zero interval
        burst = 1'b0; interval = 6'd1; mask = 4'b0011;
        pulse_start;
        while (start_o) @(negedge clk);
        drain;
        r0 = rises;
        cycles(400);
        check("R6 no round after zero interval", rises - r0, 0);
        check("R6 req low", req_o, 0);

        // R4 zero mask: one-cycle start bit, no command
        mask = '0; interval = 6'd3;
        @(negedge clk); start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        check("R4 start high one cycle", start_o, 1);
        check("R4 no command on empty mask", req_o, 0);
        @(negedge clk);
        check("R4 start cleared at second edge", start_o, 0);
        drain;

        // R7 slow acknowledge keeps spacing
        mask = 4'b0001; interval = 6'd1; burst = 1'b0;
        pulse_start;
        while (start_o) @(negedge clk);
        mode = 2; dly = 0;
        wait_rise(t1); wait_rise(t2);
        check("R7 period with slow ack", t2 - t1, 32);

        // R8 single pending round
        mode = 0;
        cycles(40);
        mode = 1;
        wait_rise(t1);
        cycles(100);
        mode = 3;
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        check("R8 queued round follows", req_o, 1);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        check("R8 only one round queued", req_o, 0);
        cycles(2);
        check("R8 queue stays empty", req_o, 0);
        mode = 0;
        drain;

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule